// File: doc/BRIEF.md
# Frame Header Inserter and Checker

This block sits on the bit path of an OFDM modem. It handles one bit per beat in both directions. On the transmit side it takes payload bits from a ready/valid source. Before each frame's payload it sends a fixed 10-bit header, the constant `1010010001`, most significant bit first. While the header goes out it holds the source off. It then passes the payload through unchanged. The frame ends on the beat that carries `last`.

On the receive side it takes the demodulated bit stream together with frame-start and frame-end markers. It compares the first ten valid bits of each frame with the same header constant. The remaining bits of the frame reach the output stream only if all ten matched. The whole header is known before the first payload bit arrives, so accepted bits are forwarded without buffering. A frame that fails the check is dropped in full, and a saturating counter records it.

Top module: `frame_hdr_codec`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `tx_out_valid`, `tx_out_last`, `rx_out_valid` and `rx_out_last` are 0, `rx_reject_cnt` is 0 and `tx_in_ready` is 0, because the transmit side starts in its header phase.
- R2: Before the payload of every frame, the transmit output carries the header bits 1,0,1,0,0,1,0,0,0,1 in that order, with `tx_out_last` at 0. Each header bit appears one cycle after a cycle in which `tx_in_valid` is high during the header phase. If `tx_in_valid` is low, no header bit is sent.
- R3: `tx_in_ready` is 0 for the whole header phase and 1 for the whole payload phase.
- R4: A payload beat is accepted when `tx_in_valid` and `tx_in_ready` are both high. One cycle later it appears on `tx_out_data` with the same `tx_out_last`, and `tx_out_valid` is 1.
- R5: After an accepted beat with `tx_in_last` high, the transmit side returns to its header phase, so every frame gets its own header.
- R6: A receive frame starts on a beat with `rx_in_valid` and `rx_in_sof` both high, and that beat is the first header bit. Beats with `rx_in_valid` low are ignored. Beats that arrive outside a frame (before any start marker, or after an end marker) without a start marker are ignored and forward nothing.
- R7: If the ten header bits of a frame equal `1010010001` (first bit = MSB), every later bit of that frame appears on `rx_out_data` one cycle after it arrives, with `rx_out_valid` at 1. `rx_out_last` is 1 for the bit that came with `rx_in_eof`.
- R8: If any of the ten header bits differs from the constant, no bit of that frame is forwarded.
- R9: A start marker that arrives inside a frame, whether in its header or its payload, abandons that frame and begins a new header check with the current bit.
- R10: `rx_reject_cnt` rises by one on the beat that completes a mismatching header, with a latency of one cycle. It stays at its all-ones value once it gets there.
- R11: An end marker that arrives before the tenth header bit closes the frame. Nothing is forwarded for it and no reject is counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_in_data | input | 1 | Transmit payload bit |
| tx_in_valid | input | 1 | Transmit payload bit present |
| tx_in_last | input | 1 | Final payload bit of the frame |
| tx_in_ready | output | 1 | Transmit side accepts a payload bit |
| tx_out_data | output | 1 | Transmit stream bit (header or payload) |
| tx_out_valid | output | 1 | Transmit stream bit present |
| tx_out_last | output | 1 | Final bit of the transmitted frame |
| rx_in_data | input | 1 | Received bit |
| rx_in_valid | input | 1 | Received bit present |
| rx_in_sof | input | 1 | Received bit is the first of a frame |
| rx_in_eof | input | 1 | Received bit is the last of a frame |
| rx_out_data | output | 1 | Forwarded payload bit |
| rx_out_valid | output | 1 | Forwarded payload bit present |
| rx_out_last | output | 1 | Final forwarded bit of an accepted frame |
| rx_reject_cnt | output | REJ_W | Saturating count of frames with a bad header |

## Verification
On the transmit side, frames of one, five and twenty bits are sent with a steady source and again with random valid gaps. The steady runs show that header timing is correct. The gapped runs show that a header bit is sent only when the source has data. The one-bit frame checks that the header comes back after a frame that is its own last beat. On the receive side, the stream includes matching frames with long, one-bit and empty payloads, and frames with each of the ten header positions flipped. These show that every bit position is compared and that the check covers the whole header, not just part of it. Further patterns cover stray bits outside any frame, an end marker inside the header, start markers that abandon a header or a payload, and enough rejects to reach saturation. Each of these separates one control path from the others.

// File: rtl/frame_hdr_pkg.sv
package frame_hdr_pkg;

  localparam int          HDR_W_DEF   = 10;
  localparam logic [9:0]  HDR_VAL_DEF = 10'b1010010001;

  typedef enum logic [1:0] {
    RX_IDLE = 2'd0,
    RX_HDR  = 2'd1,
    RX_PASS = 2'd2,
    RX_DROP = 2'd3
  } rx_state_e;

endpackage

// File: rtl/hdr_sat_counter.sv
module hdr_sat_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] count
);

  localparam logic [W-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (inc && count != TOP) begin
      count <= count + 1'b1;
    end
  end

endmodule

// File: rtl/hdr_tx_inserter.sv
module hdr_tx_inserter #(
  parameter int               HDR_W   = 10,
  parameter logic [HDR_W-1:0] HDR_VAL = '0
) (
  input  logic clk,
  input  logic rst,
  input  logic in_data,
  input  logic in_valid,
  input  logic in_last,
  output logic in_ready,
  output logic out_data,
  output logic out_valid,
  output logic out_last
);

  localparam int             CW      = $clog2(HDR_W + 1);
  localparam logic [CW-1:0]  PAY_IDX = CW'(HDR_W);

  // position in header; PAY_IDX means payload phase
  logic [CW-1:0] pos;
  logic          in_hdr;
  logic          hdr_bit;

  assign in_hdr   = (pos != PAY_IDX);
  assign in_ready = !in_hdr;

  always_comb begin
    hdr_bit = 1'b0;
    for (int i = 0; i < HDR_W; i++) begin
      if (pos == CW'(i)) hdr_bit = HDR_VAL[HDR_W-1-i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos       <= '0;
      out_data  <= 1'b0;
      out_valid <= 1'b0;
      out_last  <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      if (in_valid) begin
        out_valid <= 1'b1;
        if (in_hdr) begin
          out_data <= hdr_bit;
          pos      <= pos + 1'b1;
        end else begin
          out_data <= in_data;
          out_last <= in_last;
          if (in_last) pos <= '0;
        end
      end
    end
  end

endmodule

// File: rtl/hdr_rx_checker.sv
module hdr_rx_checker
  import frame_hdr_pkg::*;
#(
  parameter int               HDR_W   = 10,
  parameter logic [HDR_W-1:0] HDR_VAL = '0
) (
  input  logic clk,
  input  logic rst,
  input  logic in_data,
  input  logic in_valid,
  input  logic in_sof,
  input  logic in_eof,
  output logic out_data,
  output logic out_valid,
  output logic out_last,
  output logic reject
);

  localparam int CW = $clog2(HDR_W + 1);

  rx_state_e     state;
  logic [CW-1:0] cnt;
  logic          ok;

  logic [CW-1:0] idx_now;
  logic          ok_now;
  logic          hdr_beat;
  logic          hdr_end;
  logic          exp_bit;

  always_comb begin
    hdr_beat = in_valid && (in_sof || state == RX_HDR);
    idx_now  = in_sof ? '0 : cnt;
    exp_bit  = 1'b0;
    for (int i = 0; i < HDR_W; i++) begin
      if (idx_now == CW'(i)) exp_bit = HDR_VAL[HDR_W-1-i];
    end
    ok_now  = (in_sof ? 1'b1 : ok) && (in_data == exp_bit);
    hdr_end = (idx_now == CW'(HDR_W - 1));
  end

  assign reject = hdr_beat && hdr_end && !ok_now;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= RX_IDLE;
      cnt       <= '0;
      ok        <= 1'b0;
      out_data  <= 1'b0;
      out_valid <= 1'b0;
      out_last  <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      if (hdr_beat) begin
        cnt <= idx_now + 1'b1;
        ok  <= ok_now;
        if (in_eof)       state <= RX_IDLE;
        else if (hdr_end) state <= ok_now ? RX_PASS : RX_DROP;
        else              state <= RX_HDR;
      end else if (in_valid && state == RX_PASS) begin
        out_valid <= 1'b1;
        out_data  <= in_data;
        out_last  <= in_eof;
        if (in_eof) state <= RX_IDLE;
      end else if (in_valid && state == RX_DROP) begin
        if (in_eof) state <= RX_IDLE;
      end
    end
  end

endmodule

// File: rtl/frame_hdr_codec.sv
module frame_hdr_codec
  import frame_hdr_pkg::*;
#(
  parameter int               HDR_W   = HDR_W_DEF,
  parameter logic [HDR_W-1:0] HDR_VAL = HDR_VAL_DEF,
  parameter int               REJ_W   = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tx_in_data,
  input  logic             tx_in_valid,
  input  logic             tx_in_last,
  output logic             tx_in_ready,
  output logic             tx_out_data,
  output logic             tx_out_valid,
  output logic             tx_out_last,
  input  logic             rx_in_data,
  input  logic             rx_in_valid,
  input  logic             rx_in_sof,
  input  logic             rx_in_eof,
  output logic             rx_out_data,
  output logic             rx_out_valid,
  output logic             rx_out_last,
  output logic [REJ_W-1:0] rx_reject_cnt
);

  logic reject_pulse;

  hdr_tx_inserter #(
    .HDR_W   (HDR_W),
    .HDR_VAL (HDR_VAL)
  ) u_tx (
    .clk       (clk),
    .rst       (rst),
    .in_data   (tx_in_data),
    .in_valid  (tx_in_valid),
    .in_last   (tx_in_last),
    .in_ready  (tx_in_ready),
    .out_data  (tx_out_data),
    .out_valid (tx_out_valid),
    .out_last  (tx_out_last)
  );

  hdr_rx_checker #(
    .HDR_W   (HDR_W),
    .HDR_VAL (HDR_VAL)
  ) u_rx (
    .clk       (clk),
    .rst       (rst),
    .in_data   (rx_in_data),
    .in_valid  (rx_in_valid),
    .in_sof    (rx_in_sof),
    .in_eof    (rx_in_eof),
    .out_data  (rx_out_data),
    .out_valid (rx_out_valid),
    .out_last  (rx_out_last),
    .reject    (reject_pulse)
  );

  hdr_sat_counter #(
    .W (REJ_W)
  ) u_rej (
    .clk   (clk),
    .rst   (rst),
    .inc   (reject_pulse),
    .count (rx_reject_cnt)
  );

endmodule

// File: rtl/frame_hdr_codec_chk.sv
module frame_hdr_codec_chk #(
  parameter int REJ_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             tx_in_data,
  input logic             tx_in_valid,
  input logic             tx_in_last,
  input logic             tx_in_ready,
  input logic             tx_out_data,
  input logic             tx_out_valid,
  input logic             tx_out_last,
  input logic             rx_in_valid,
  input logic             rx_in_sof,
  input logic             rx_out_valid,
  input logic             rx_out_last,
  input logic [REJ_W-1:0] rx_reject_cnt
);

  localparam logic [REJ_W-1:0] REJ_TOP = '1;

  // R2
  hdr_emit_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_in_valid && !tx_in_ready) |=> (tx_out_valid && !tx_out_last));

  // R4
  pay_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_in_valid && tx_in_ready) |=>
      (tx_out_valid && tx_out_data == $past(tx_in_data) && tx_out_last == $past(tx_in_last)));

  // R5
  new_hdr_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_in_valid && tx_in_ready && tx_in_last) |=> !tx_in_ready);

  // R2
  tx_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !tx_in_valid |=> !tx_out_valid);

  // R6
  rx_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !rx_in_valid |=> !rx_out_valid);

  // R9
  sof_no_fwd_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_in_valid && rx_in_sof) |=> !rx_out_valid);

  // R7
  rx_last_chk: assert property (@(posedge clk) disable iff (rst)
    rx_out_last |-> rx_out_valid);

  // R10
  rej_step_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (rx_reject_cnt == $past(rx_reject_cnt) ||
              rx_reject_cnt == $past(rx_reject_cnt) + 1'b1));

  // R10
  rej_sat_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_reject_cnt == REJ_TOP) |=> (rx_reject_cnt == REJ_TOP));

endmodule

bind frame_hdr_codec frame_hdr_codec_chk #(.REJ_W(REJ_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .tx_in_data    (tx_in_data),
  .tx_in_valid   (tx_in_valid),
  .tx_in_last    (tx_in_last),
  .tx_in_ready   (tx_in_ready),
  .tx_out_data   (tx_out_data),
  .tx_out_valid  (tx_out_valid),
  .tx_out_last   (tx_out_last),
  .rx_in_valid   (rx_in_valid),
  .rx_in_sof     (rx_in_sof),
  .rx_out_valid  (rx_out_valid),
  .rx_out_last   (rx_out_last),
  .rx_reject_cnt (rx_reject_cnt)
);

// File: tb/frame_hdr_codec_tb_top.sv
module frame_hdr_codec_tb_top;

  localparam int         HW    = 10;
  localparam logic [9:0] HCONST = 10'b1010010001;
  localparam int         RW    = 4;
  localparam int         RMAX  = (1 << RW) - 1;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst = 1'b1;
  logic tx_in_data = 1'b0, tx_in_valid = 1'b0, tx_in_last = 1'b0;
  logic rx_in_data = 1'b0, rx_in_valid = 1'b0, rx_in_sof = 1'b0, rx_in_eof = 1'b0;
  logic tx_in_ready, tx_out_data, tx_out_valid, tx_out_last;
  logic rx_out_data, rx_out_valid, rx_out_last;
  logic [RW-1:0] rx_reject_cnt;

  frame_hdr_codec #(.REJ_W(RW)) dut_i (
    .clk(clk), .rst(rst),
    .tx_in_data(tx_in_data), .tx_in_valid(tx_in_valid), .tx_in_last(tx_in_last),
    .tx_in_ready(tx_in_ready), .tx_out_data(tx_out_data),
    .tx_out_valid(tx_out_valid), .tx_out_last(tx_out_last),
    .rx_in_data(rx_in_data), .rx_in_valid(rx_in_valid), .rx_in_sof(rx_in_sof),
    .rx_in_eof(rx_in_eof), .rx_out_data(rx_out_data), .rx_out_valid(rx_out_valid),
    .rx_out_last(rx_out_last), .rx_reject_cnt(rx_reject_cnt)
  );

  int    checks = 0;
  int    errors = 0;
  bit    done   = 0;
  string tag    = "R1";

  // next-cycle drive values
  bit d_rst = 1, d_td, d_tv, d_tl, d_rd, d_rv, d_rsof, d_reof;

  // reference model state and expected outputs
  int t_idx = 0;
  int r_ph = 0, r_cnt = 0, rej = 0;
  bit r_ok = 0;
  bit e_tv = 0, e_td = 0, e_tl = 0, e_rv = 0, e_rd = 0, e_rl = 0;

  bit rxq[$];

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model_step();
    if (d_rst) begin
      t_idx = 0; r_ph = 0; r_cnt = 0; r_ok = 0; rej = 0;
      e_tv = 0; e_tl = 0; e_rv = 0; e_rl = 0;
      return;
    end
    // transmit
    e_tv = 0; e_tl = 0;
    if (d_tv) begin
      e_tv = 1;
      if (t_idx < HW) begin
        e_td = HCONST[HW-1-t_idx];
        t_idx++;
      end else begin
        e_td = d_td; e_tl = d_tl;
        if (d_tl) t_idx = 0;
      end
    end
    // receive
    e_rv = 0; e_rl = 0;
    if (d_rv) begin
      if (d_rsof || r_ph == 1) begin
        if (d_rsof) begin r_cnt = 0; r_ok = 1; end
        r_ok = r_ok && (d_rd == HCONST[HW-1-r_cnt]);
        r_cnt++;
        if (r_cnt == HW && !r_ok && rej < RMAX) rej++;
        if (d_reof)          r_ph = 0;
        else if (r_cnt == HW) r_ph = r_ok ? 2 : 3;
        else                 r_ph = 1;
      end else if (r_ph == 2) begin
        e_rv = 1; e_rd = d_rd; e_rl = d_reof;
        if (d_reof) r_ph = 0;
      end else if (r_ph == 3) begin
        if (d_reof) r_ph = 0;
      end
    end
  endtask

  task automatic tick();
    @(negedge clk);
    chk("tx_out_valid", tx_out_valid, e_tv);
    if (e_tv) begin
      chk("tx_out_data", tx_out_data, e_td);
      chk("tx_out_last", tx_out_last, e_tl);
    end
    chk("tx_in_ready", tx_in_ready, (t_idx == HW));
    chk("rx_out_valid", rx_out_valid, e_rv);
    if (e_rv) begin
      chk("rx_out_data", rx_out_data, e_rd);
      chk("rx_out_last", rx_out_last, e_rl);
    end
    chk("rx_reject_cnt", rx_reject_cnt, rej);
    rst = d_rst;
    tx_in_data = d_td; tx_in_valid = d_tv; tx_in_last = d_tl;
    rx_in_data = d_rd; rx_in_valid = d_rv; rx_in_sof = d_rsof; rx_in_eof = d_reof;
    model_step();
  endtask

  task automatic tx_frame(input int n, input int gap_pct);
    int k = 0;
    while (k < n) begin
      bit rdy = (t_idx == HW);
      d_tv = (($urandom % 100) >= gap_pct);
      d_td = $urandom % 2;
      d_tl = (k == n - 1);
      tick();
      if (d_tv && rdy) k++;
    end
    d_tv = 0; d_tl = 0;
  endtask

  task automatic rx_send(input bit with_eof, input int gap_pct);
    for (int i = 0; i < rxq.size(); i++) begin
      while (($urandom % 100) < gap_pct) begin
        d_rv = 0; d_rd = $urandom % 2; d_rsof = $urandom % 2; d_reof = $urandom % 2;
        tick();
      end
      d_rv = 1; d_rd = rxq[i];
      d_rsof = (i == 0);
      d_reof = with_eof && (i == rxq.size() - 1);
      tick();
    end
    d_rv = 0; d_rsof = 0; d_reof = 0;
    rxq.delete();
  endtask

  task automatic rx_build(input logic [9:0] hdr, input int nhdr, input int npay);
    for (int i = 0; i < nhdr; i++) rxq.push_back(hdr[HW-1-i]);
    for (int i = 0; i < npay; i++) rxq.push_back($urandom % 2);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    tag = "R1";
    d_rst = 1;
    repeat (3) tick();
    d_rst = 0;
    tick();
    tick();

    // R2 R3 R4 R5: transmit frames, steady and gapped source
    tag = "R2 R3 R4 R5";
    tx_frame(5, 0);
    tx_frame(1, 0);
    tx_frame(20, 0);
    repeat (3) tick();
    tx_frame(5, 50);
    tx_frame(1, 50);
    tx_frame(20, 30);
    repeat (4) tick();

    // R6: stray bits outside any frame
    tag = "R6";
    for (int i = 0; i < 6; i++) begin
      d_rv = 1; d_rd = $urandom % 2; d_rsof = 0; d_reof = (i == 3);
      tick();
    end
    d_rv = 0; d_reof = 0;
    tick();

    // R7: matching headers, long, single and empty payloads
    tag = "R7";
    rx_build(HCONST, HW, 12); rx_send(1, 0);
    rx_build(HCONST, HW, 1);  rx_send(1, 0);
    rx_build(HCONST, HW, 0);  rx_send(1, 0);
    rx_build(HCONST, HW, 9);  rx_send(1, 40);
    // R6: bits after the end marker are ignored
    tag = "R6";
    for (int i = 0; i < 4; i++) begin
      d_rv = 1; d_rd = 1; d_rsof = 0; d_reof = 0;
      tick();
    end
    d_rv = 0;
    tick();

    // R8 R10: each header bit flipped in turn
    tag = "R8 R10";
    for (int p = 0; p < HW; p++) begin
      rx_build(HCONST ^ (10'b1000000000 >> p), HW, 5);
      rx_send(1, (p % 2) * 30);
    end

    // R11: end marker inside the header
    tag = "R11";
    rx_build(HCONST, 4, 0); rx_send(1, 0);
    rx_build(~HCONST, 7, 0); rx_send(1, 0);
    tick();

    // R9: new start marker aborts a payload and a header
    tag = "R9";
    rx_build(HCONST, HW, 3); rx_send(0, 0);
    rx_build(HCONST, 6, 0);  rx_send(0, 0);
    rx_build(HCONST, HW, 4); rx_send(1, 20);
    rx_build(HCONST, HW, 2); rx_send(0, 0);
    rx_build(~HCONST, HW, 3); rx_send(1, 0);

    // R10: drive the counter into saturation
    tag = "R10";
    for (int i = 0; i < 8; i++) begin
      rx_build(HCONST ^ 10'b0000000001, HW, 2);
      rx_send(1, 0);
    end
    rx_build(HCONST, HW, 6); rx_send(1, 0);
    tick();
    tag = "R10";
    chk("rx_reject_cnt saturated", rx_reject_cnt, RMAX);

    // R1: reset again mid-traffic
    tag = "R1";
    d_tv = 1; d_td = 1;
    tick();
    d_rst = 1;
    tick();
    d_tv = 0;
    tick();
    d_rst = 0;
    tick();
    tick();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule